// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Transfer

This block moves one data word at a time between an initiating controller and a responding storage controller. The transfer is paced only by a return-to-zero exchange on two strobes, request and acknowledge. No shared transfer clock paces it. Local logic asks for a transfer with a one-cycle start strobe, giving a direction bit, a word address and write data. The initiator places address, direction and data on the bus and leaves them untouched for a settle window of `DECODE` cycles. Only then does it raise request.

The responder captures write data, or presents read data from its word store, and raises acknowledge. The initiator sees acknowledge and lowers request, taking the read word at that moment. The responder then lowers acknowledge. Once the initiator sees acknowledge low again, it reports completion with a one-cycle done pulse and can accept the next start.

Both controllers share one clock here, but each strobe they receive passes through a two-stage synchronizer, as it would if it crossed clock domains. Each phase of the handshake therefore costs a fixed number of cycles. The two strobes are also brought out as observation outputs.

Top module: `hs_bus_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, busy, done, bus_req, bus_ack and rdata are all 0.
- R2: A start seen at a clock edge while idle makes busy 1 after that edge. bus_req then stays 0 for `DECODE` (default 2) further edges and becomes 1 at the edge `DECODE` cycles after the accepting edge.
- R3: bus_ack becomes 1 exactly 3 edges after bus_req rises (two synchronizer stages plus one register). On a write (wr_en = 1), the word wdata is stored at address addr.
- R4: bus_req returns to 0 exactly 3 edges after bus_ack rises. On a read (wr_en = 0), rdata then holds the word most recently written to that address.
- R5: bus_ack returns to 0 exactly 3 edges after bus_req falls.
- R6: done is a one-cycle pulse that appears exactly 3 edges after bus_ack falls, which is `DECODE`+12 edges after the accepting edge. busy falls to 0 at the same edge.
- R7: A write transfer leaves rdata unchanged.
- R8: A start raised while busy is 1 has no effect: it produces no extra done and writes nothing. A start given in the cycle that done is high is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a transfer |
| wr_en | input | 1 | Direction: 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Word returned by the last read |
| bus_req | output | 1 | Observed request strobe |
| bus_ack | output | 1 | Observed acknowledge strobe |

## Verification
Counting from the edge that accepts start, bus_req is due to rise after `DECODE` edges. Each later strobe change is due a further 3 edges after the previous one, so done is due at edge `DECODE`+12. The bench samples every cycle of each transfer on the falling edge and compares busy, done and both strobes against a schedule computed from that count. Read words and the unchanged rdata after writes are checked by a queue-based scoreboard when done is sampled high. A start injected mid-transfer is then judged by the absence of an unexpected done and by a later read of the targeted word.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_REQ   = 2'd2,
    M_REL   = 2'd3
  } m_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int DECODE = 2,
  parameter int SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_req,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int CW = (DECODE < 2) ? 1 : $clog2(DECODE);

  m_state_t      state;
  logic [CW-1:0] cnt;
  logic          ack_s;

  hs_sync #(.STAGES(SYNC)) ack_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (bus_ack),
    .q   (ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_IDLE;
      cnt       <= '0;
      bus_req   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_addr  <= '0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        M_IDLE: begin
          if (start && !ack_s) begin
            bus_addr  <= addr;
            bus_wr    <= wr_en;
            bus_wdata <= wdata;
            busy      <= 1'b1;
            cnt       <= '0;
            state     <= M_SETUP;
          end
        end
        M_SETUP: begin
          if (cnt == CW'(DECODE - 1)) begin
            bus_req <= 1'b1;
            state   <= M_REQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_REQ: begin
          if (ack_s) begin
            bus_req <= 1'b0;
            if (!bus_wr) rdata <= bus_rdata;
            state <= M_REL;
          end
        end
        M_REL: begin
          if (!ack_s) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_slave.sv
module hs_slave #(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_req,
  output logic          bus_ack,
  output logic [DW-1:0] bus_rdata
);
  localparam int DEPTH = 1 << AW;

  logic          req_s;
  logic          roe;
  logic          cap;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mem [DEPTH];

  hs_sync #(.STAGES(SYNC)) req_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (bus_req),
    .q   (req_s)
  );

  assign cap = req_s && !bus_ack;

  always_ff @(posedge clk) begin
    if (cap && bus_wr) mem[bus_addr] <= bus_wdata;
    rd_q <= mem[bus_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      roe     <= 1'b0;
    end else if (cap) begin
      bus_ack <= 1'b1;
      roe     <= !bus_wr;
    end else if (!req_s && bus_ack) begin
      bus_ack <= 1'b0;
      roe     <= 1'b0;
    end
  end

  assign bus_rdata = roe ? rd_q : '0;
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int DECODE = 2,
  parameter int SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  output logic          bus_ack
);
  logic [AW-1:0] b_addr;
  logic          b_wr;
  logic [DW-1:0] b_wdata;
  logic [DW-1:0] b_rdata;

  hs_master #(.AW(AW), .DW(DW), .DECODE(DECODE), .SYNC(SYNC)) mst_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .bus_addr  (b_addr),
    .bus_wr    (b_wr),
    .bus_wdata (b_wdata),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rdata (b_rdata)
  );

  hs_slave #(.AW(AW), .DW(DW), .SYNC(SYNC)) slv_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (b_addr),
    .bus_wr    (b_wr),
    .bus_wdata (b_wdata),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rdata (b_rdata)
  );
endmodule

// File: rtl/hs_bus_chk.sv
module hs_bus_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic req,
  input logic ack
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !req && !ack));

  // R2
  req_rise_ack_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(req) |-> (!ack && busy));

  // R3
  ack_rise_req_high_chk: assert property (@(posedge clk) disable iff (rst) $rose(ack) |-> req);

  // R4
  req_fall_ack_high_chk: assert property (@(posedge clk) disable iff (rst) $fell(req) |-> ack);

  // R5
  ack_fall_req_low_chk: assert property (@(posedge clk) disable iff (rst) $fell(ack) |-> !req);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && !req && !ack));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
endmodule

bind hs_bus_top hs_bus_chk chk_i (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .req   (bus_req),
  .ack   (bus_ack)
);

// File: tb/hs_bus_top_tb_top.sv
module hs_bus_top_tb_top;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int DECODE = 2;
  localparam int SYNC   = 2;
  localparam int PH     = SYNC + 1;
  localparam int TOT    = DECODE + 4 * PH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done, bus_req, bus_ack;
  logic [DW-1:0] rdata;

  int            n_tests = 0;
  int            n_fail  = 0;
  bit            finished = 1'b0;
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] last_rd = '0;
  logic [DW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  hs_bus_top #(.AW(AW), .DW(DW), .DECODE(DECODE), .SYNC(SYNC)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .bus_req (bus_req),
    .bus_ack (bus_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: every done pops one expected rdata value (R4, R7, R8)
  always @(negedge clk) begin
    if (!rst && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected done", 32'(done), 32'd0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check("R4/R7 rdata", 32'(rdata), 32'(e));
      end
    end
  end

  // Driver: one transfer with per-cycle strobe schedule check (R2..R6)
  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit inject);
    if (w) model[a] = d;
    else   last_rd = model[a];
    exp_q.push_back(last_rd);
    start = 1'b1; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= TOT; t++) begin
      logic [3:0] e, g;
      string tag;
      e = {(t >= DECODE && t < DECODE + 2 * PH),
           (t >= DECODE + PH && t < DECODE + 3 * PH),
           (t < TOT), (t == TOT)};
      g = {bus_req, bus_ack, busy, done};
      if      (t <= DECODE)          tag = "R2 req/ack/busy/done";
      else if (t <= DECODE + PH)     tag = "R3 req/ack/busy/done";
      else if (t <= DECODE + 2 * PH) tag = "R4 req/ack/busy/done";
      else if (t <= DECODE + 3 * PH) tag = "R5 req/ack/busy/done";
      else                           tag = "R6 req/ack/busy/done";
      check(tag, 32'(g), 32'(e));
      if (inject && t == 4) begin
        start = 1'b1; wr_en = 1'b1; addr = 4'd9; wdata = 8'hEE;
      end else begin
        start = 1'b0;
      end
      if (t < TOT) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 busy",  32'(busy),  0);
    check("R1 done",  32'(done),  0);
    check("R1 req",   32'(bus_req), 0);
    check("R1 ack",   32'(bus_ack), 0);
    check("R1 rdata", 32'(rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after release", 32'(busy), 0);
    check("R1 strobes after release", 32'({bus_req, bus_ack}), 0);

    // R3: fill every word, back to back (R8 acceptance right after done)
    for (int i = 0; i < (1 << AW); i++)
      xfer(1'b1, AW'(i), DW'(i * 37 + 8'h11), 1'b0);
    // R7: rdata still 0 after writes
    check("R7 rdata after writes", 32'(rdata), 0);

    // R4: read several words in varied order
    xfer(1'b0, 4'd5, '0, 1'b0);
    xfer(1'b0, 4'd0, '0, 1'b0);
    xfer(1'b0, 4'd15, '0, 1'b0);
    xfer(1'b1, 4'd5, 8'hA5, 1'b0);
    xfer(1'b0, 4'd5, '0, 1'b0);
    xfer(1'b1, 4'd0, 8'hFF, 1'b0);
    check("R7 rdata held over write", 32'(rdata), 32'(model[5]));
    xfer(1'b0, 4'd0, '0, 1'b0);

    // R8: start raised mid-transfer aimed at word 9 must be ignored
    xfer(1'b0, 4'd3, '0, 1'b1);
    repeat (TOT + 4) @(negedge clk);
    check("R8 no extra activity", 32'({busy, bus_req, bus_ack}), 0);
    xfer(1'b0, 4'd9, '0, 1'b0);
    check("R8 word 9 untouched", 32'(rdata), 32'(model[9]));

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule